// File: doc/BRIEF.md
# Display Self-Test Pattern Generator

This block makes a monitor drive itself without any input signal. While its enable input is high it produces free-running horizontal and vertical sync pulses and a one-bit video level. The video level is a grid, the inverse of that grid, solid white or solid black, chosen by a two-bit pattern code. A two-bit timing code picks one of four pairs of line rate and frame rate. Every period is a whole number of clocks derived from the `CLK_HZ` parameter, so any system clock can be used.

A new timing code or pattern code is applied at the next frame boundary. If the enable input rises, the codes present at that moment apply from the first clock. When the enable input is low, all outputs stay low and both position counters are held at zero.

Top module: `stp_gen`

## Requirements
- R1: While `en` is low, `hsync`, `vsync` and `video` are low and both counters are held at zero. In the first cycle after `en` is sampled high, the outputs show line 0, pixel 0 of a new frame.
- R2: The line period in clocks is round(CLK_HZ / line rate). The line rate is 31750 Hz for timing code 0, 47600 Hz for code 1, 63500 Hz for code 2 and 95200 Hz for code 3.
- R3: The frame period in lines is round(line rate / frame rate). The frame rate is 60 Hz for timing codes 0, 1 and 2, and 72 Hz for code 3. The results are 529, 793, 1058 and 1322 lines.
- R4: The width of each sync pulse is round(8% of its period), with a minimum of 1. It is counted in clocks for `hsync` and in lines for `vsync`.
- R5: Both syncs are active high. `hsync` is high from pixel 0 of every line. `vsync` is high from line 0 of every frame.
- R6: Pattern code 0 (grid) sets `video` high when the pixel index or the line index is a multiple of 16, and low otherwise.
- R7: Pattern code 1 (inverse grid) sets `video` to the inverse of the pattern code 0 value.
- R8: Pattern code 2 holds `video` high. Pattern code 3 holds `video` low.
- R9: `video` is low in every cycle in which `hsync` or `vsync` is high.
- R10: A change of `tmode` or `pmode` while running takes effect on the first pixel of the next frame. Until then the current frame keeps its old timing and pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Generator enable |
| tmode | input | 2 | Timing code (line and frame rate) |
| pmode | input | 2 | Pattern code |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| video | output | 1 | One-bit video level |

## Verification
The frame boundary that loads a new mode lands in the same cycle as the wrap of both counters. That cycle is also the start of a line pulse and a frame pulse under the new timing. The bench changes `tmode` and `pmode` at random points in the middle of a frame and keeps them there across the boundary. A cycle-by-cycle model, built from the requirements, must then show the old periods up to the boundary, and the new sync widths and the new pattern from the first pixel after it. The same cycles also check R9, because the video level from the new pattern has to stay blanked during the first sync pulses of the new frame.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [1:0] {
        TM_31K = 2'd0,
        TM_47K = 2'd1,
        TM_63K = 2'd2,
        TM_95K = 2'd3
    } timing_e;

    typedef enum logic [1:0] {
        PAT_GRID   = 2'd0,
        PAT_GRID_N = 2'd1,
        PAT_WHITE  = 2'd2,
        PAT_BLACK  = 2'd3
    } pattern_e;

    localparam int unsigned GRID_LOG2 = 4;

    function automatic int unsigned rdiv(input int unsigned num, input int unsigned den);
        return (2 * num + den) / (2 * den);
    endfunction

    function automatic int unsigned line_rate(input int unsigned code);
        case (code)
            0:       return 31750;
            1:       return 47600;
            2:       return 63500;
            default: return 95200;
        endcase
    endfunction

    function automatic int unsigned frame_rate(input int unsigned code);
        return (code == 3) ? 72 : 60;
    endfunction

    function automatic int unsigned line_clocks(input int unsigned clk_hz, input int unsigned code);
        return rdiv(clk_hz, line_rate(code));
    endfunction

    function automatic int unsigned frame_lines(input int unsigned code);
        return rdiv(line_rate(code), frame_rate(code));
    endfunction

    function automatic int unsigned pulse_len(input int unsigned period);
        int unsigned w;
        w = rdiv(period * 8, 100);
        return (w == 0) ? 1 : w;
    endfunction

endpackage

// File: rtl/stp_mode_ctrl.sv
module stp_mode_ctrl
    import stp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     frame_end,
    input  timing_e  tmode_in,
    input  pattern_e pmode_in,
    output logic     run,
    output timing_e  tmode_act,
    output pattern_e pmode_act
);

    typedef struct packed {
        logic     run;
        timing_e  tm;
        pattern_e pt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.run = en;
        if (en && (!st_q.run || frame_end)) begin
            st_d.tm = tmode_in;
            st_d.pt = pmode_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{run: 1'b0, tm: TM_31K, pt: PAT_GRID};
        end else begin
            st_q <= st_d;
        end
    end

    assign run       = st_q.run;
    assign tmode_act = st_q.tm;
    assign pmode_act = st_q.pt;

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && $past(en) && !$past(frame_end))
        |-> ($stable(st_q.tm) && $stable(st_q.pt)));

endmodule

// File: rtl/stp_count.sv
module stp_count #(
    parameter int unsigned W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         step,
    input  logic [W-1:0] last,
    output logic [W-1:0] value,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    assign wrap = go && step && (st_q.cnt == last);

    always_comb begin
        st_d = st_q;
        if (!go) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = (st_q.cnt == last) ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;

    // R1
    held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (value == '0));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        value <= last);

endmodule

// File: rtl/stp_video.sv
module stp_video
    import stp_pkg::*;
#(
    parameter int unsigned HW = 11,
    parameter int unsigned VW = 11
) (
    input  logic          run,
    input  logic          blank,
    input  pattern_e      pat,
    input  logic [HW-1:0] hpos,
    input  logic [VW-1:0] vpos,
    output logic          video
);

    logic grid;
    logic level;

    assign grid = (hpos[GRID_LOG2-1:0] == '0) || (vpos[GRID_LOG2-1:0] == '0);

    always_comb begin
        case (pat)
            PAT_GRID:   level = grid;
            PAT_GRID_N: level = !grid;
            PAT_WHITE:  level = 1'b1;
            default:    level = 1'b0;
        endcase
    end

    assign video = run && !blank && level;

endmodule

// File: rtl/stp_gen.sv
module stp_gen
    import stp_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] tmode,
    input  logic [1:0] pmode,
    output logic       hsync,
    output logic       vsync,
    output logic       video
);

    localparam int unsigned NMODES = 4;
    localparam int unsigned HMAX   = line_clocks(CLK_HZ, 0);
    localparam int unsigned VMAX   = frame_lines(3);
    localparam int unsigned HW     = $clog2(HMAX + 1);
    localparam int unsigned VW     = $clog2(VMAX + 1);

    logic          run;
    timing_e       tm_act;
    pattern_e      pt_act;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          h_wrap;
    logic          v_wrap;
    logic          go;
    logic          frame_end;

    logic [HW-1:0] h_last [NMODES];
    logic [HW-1:0] h_width[NMODES];
    logic [VW-1:0] v_last [NMODES];
    logic [VW-1:0] v_width[NMODES];

    for (genvar g = 0; g < NMODES; g++) begin : g_mode
        assign h_last[g]  = HW'(line_clocks(CLK_HZ, g) - 1);
        assign h_width[g] = HW'(pulse_len(line_clocks(CLK_HZ, g)));
        assign v_last[g]  = VW'(frame_lines(g) - 1);
        assign v_width[g] = VW'(pulse_len(frame_lines(g)));
    end

    logic [HW-1:0] h_last_sel;
    logic [HW-1:0] h_width_sel;
    logic [VW-1:0] v_last_sel;
    logic [VW-1:0] v_width_sel;

    assign h_last_sel  = h_last[tm_act];
    assign h_width_sel = h_width[tm_act];
    assign v_last_sel  = v_last[tm_act];
    assign v_width_sel = v_width[tm_act];

    assign go        = en && run;
    assign frame_end = h_wrap && v_wrap;

    stp_mode_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .frame_end (frame_end),
        .tmode_in  (timing_e'(tmode)),
        .pmode_in  (pattern_e'(pmode)),
        .run       (run),
        .tmode_act (tm_act),
        .pmode_act (pt_act)
    );

    stp_count #(.W(HW)) u_hcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .step  (1'b1),
        .last  (h_last_sel),
        .value (hcnt),
        .wrap  (h_wrap)
    );

    stp_count #(.W(VW)) u_vcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .step  (h_wrap),
        .last  (v_last_sel),
        .value (vcnt),
        .wrap  (v_wrap)
    );

    assign hsync = run && (hcnt < h_width_sel);
    assign vsync = run && (vcnt < v_width_sel);

    stp_video #(.HW(HW), .VW(VW)) u_video (
        .run   (run),
        .blank (hsync || vsync),
        .pat   (pt_act),
        .hpos  (hcnt),
        .vpos  (vcnt),
        .video (video)
    );

    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!hsync && !vsync && !video));

    // R9
    sync_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync || vsync) |-> !video);

    // R5
    hsync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> (hcnt == '0));

    // R4
    hsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hsync) && run) |-> (hcnt == h_width_sel));

endmodule

// File: tb/tb_stp_gen.sv
module tb_stp_gen;

    localparam int unsigned CLK_HZ = 1_600_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] tmode = 2'd0;
    logic [1:0] pmode = 2'd0;
    logic       hsync, vsync, video;

    int checks = 0;
    int errors = 0;
    bit checking = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stp_gen #(.CLK_HZ(CLK_HZ)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tmode (tmode),
        .pmode (pmode),
        .hsync (hsync),
        .vsync (vsync),
        .video (video)
    );

    function automatic int rnd(input int n, input int d);
        return (2 * n + d) / (2 * d);
    endfunction

    function automatic int lrate(input int c);
        return (c == 0) ? 31750 : (c == 1) ? 47600 : (c == 2) ? 63500 : 95200;
    endfunction

    function automatic int hper(input int c);
        return rnd(CLK_HZ, lrate(c));
    endfunction

    function automatic int vper(input int c);
        return rnd(lrate(c), (c == 3) ? 72 : 60);
    endfunction

    function automatic int pw(input int p);
        int w;
        w = rnd(p * 8, 100);
        return (w < 1) ? 1 : w;
    endfunction

    // Reference state, built from the requirements
    bit run_m;
    int h_m, v_m, t_m, p_m;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_m <= 0; h_m <= 0; v_m <= 0; t_m <= 0; p_m <= 0;
        end else begin
            run_m <= en;
            if (en && run_m) begin
                if (h_m == hper(t_m) - 1) begin
                    h_m <= 0;
                    if (v_m == vper(t_m) - 1) begin
                        v_m <= 0;
                        t_m <= tmode;
                        p_m <= pmode;
                    end else begin
                        v_m <= v_m + 1;
                    end
                end else begin
                    h_m <= h_m + 1;
                end
            end else begin
                h_m <= 0;
                v_m <= 0;
                if (en) begin
                    t_m <= tmode;
                    p_m <= pmode;
                end
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b (t=%0d p=%0d line=%0d pix=%0d) at %0t",
                     tag, act, exp, t_m, p_m, v_m, h_m, $time);
        end
    endtask

    always @(negedge clk) begin
        if (checking) begin
            logic hs, vs, grid, lvl;
            hs = run_m && (h_m < pw(hper(t_m)));
            vs = run_m && (v_m < pw(vper(t_m)));
            grid = (h_m % 16 == 0) || (v_m % 16 == 0);
            lvl = (p_m == 0) ? grid : (p_m == 1) ? !grid : (p_m == 2);
            if (!run_m) begin
                check("R1 hsync off", hsync, 1'b0);
                check("R1 vsync off", vsync, 1'b0);
                check("R1 video off", video, 1'b0);
            end else begin
                check("R2 R4 R5 R10 hsync", hsync, hs);
                check("R3 R4 R5 R10 vsync", vsync, vs);
                if (hs || vs)
                    check("R9 video blanked", video, 1'b0);
                else if (p_m == 0)
                    check("R6 grid video", video, lvl);
                else if (p_m == 1)
                    check("R7 inverse grid video", video, lvl);
                else
                    check("R8 solid video", video, lvl);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Run for a while, changing codes at random points inside the frame
    task automatic run_with_changes(input int cycles, input int nt, input int np);
        int at;
        at = $urandom_range(cycles / 4, cycles / 2);
        wait_cyc(at);
        tmode = 2'(nt);
        pmode = 2'(np);
        wait_cyc(cycles - at);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // Reset state (R1)
        wait_cyc(3);
        check("R1 reset hsync", hsync, 1'b0);
        check("R1 reset vsync", vsync, 1'b0);
        check("R1 reset video", video, 1'b0);
        rst_n = 1'b1;
        checking = 1'b1;
        wait_cyc(5);

        // Grid at mode 0, switch mid-frame to mode 3 inverse grid (R10)
        tmode = 2'd0; pmode = 2'd0; en = 1'b1;
        @(negedge clk);
        check("R1 first pixel hsync", hsync, 1'b1);
        check("R1 first pixel vsync", vsync, 1'b1);
        run_with_changes(hper(0) * vper(0) + 200, 3, 1);
        wait_cyc(hper(3) * vper(3));

        // Disable mid-frame (R1)
        en = 1'b0;
        wait_cyc(40);
        check("R1 disabled hsync", hsync, 1'b0);
        check("R1 disabled video", video, 1'b0);

        // Re-enable in mode 2 white, then random change to mode 1 black
        tmode = 2'd2; pmode = 2'd2; en = 1'b1;
        run_with_changes(hper(2) * vper(2) + 300, 1, 3);
        wait_cyc(hper(1) * vper(1) - 100);

        // A few random short stretches with random codes and enable drops
        for (int i = 0; i < 6; i++) begin
            tmode = 2'($urandom_range(0, 3));
            pmode = 2'($urandom_range(0, 3));
            en = ($urandom_range(0, 3) != 0);
            wait_cyc($urandom_range(50, 800));
        end
        en = 1'b0;
        wait_cyc(5);

        checking = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule